// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Master with Collision Flag

This block is a bus-attached serial peripheral master. Software sets the mode in a control register, then writes one byte into the data register. The block shifts that byte out on the serial data output, most significant bit first, and generates the serial clock for it. At the same time it collects eight bits from the serial data input. When the eighth bit is done, it raises a completion flag and, if enabled, an interrupt. The received byte is then read back from the same data register.

If the data register is written while a byte is still moving, the block does not restart and does not change the byte being shifted. It only records a collision flag. Flags are cleared in two steps: a status read takes a snapshot of the flags that are set, and the next access to the data register clears only those snapshot flags.

Register map (two-bit address):
- 0: control.
- 1: status, read-only.
- 2: data.
- 3: reads zero.

Top module: `spi_byte_master`

## Requirements
- R1: Control bits [1:0] (rate) give the half-period of the serial clock in bus clocks: 1, 2, 8 or 16 for codes 0 to 3. The serial clock is therefore the bus clock divided by 2, 4, 16 or 32. A transfer takes 16 half-periods, so the completion flag becomes visible exactly 16×half-period bus clocks after the edge that accepted the data write.
- R2: Control bit 6 is the enable. While it is clear, a data register write is ignored. No clock edges are produced, the data register is unchanged, and no flag changes.
- R3: A data write while a transfer is running sets status bit 6 (collision). The byte being shifted is not changed, and the transfer finishes normally.
- R4: Data shifts out most significant bit first on the data output. The data input is sampled on the clock edge opposite to the one that changes the output. After completion, a data register read returns the received byte.
- R5: At the end of the eighth bit, status bit 7 (complete) is set. The interrupt output is high whenever that flag and control bit 7 (interrupt enable) are both set.
- R6: The serial clock idles at control bit 3 (polarity). With control bit 2 (phase) clear, the first data bit is on the output half a period before the first clock edge. With phase set, the first clock edge comes at the start of the transfer.
- R7: A status read snapshots the set flags. A later data read, or an enabled data write, clears the snapshot flags.
- R8: Writes to the status register have no effect. Status bit 4 (mode fault) always reads zero.
- R9: A flag that sets after the status read and before the data access is not cleared by that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The edge that accepts a data write loads the byte. One bus clock later, the bench checks that the first data bit and the starting clock level are on the pins. The completion flag and interrupt are due exactly 16×half-period clocks after the accepting edge. The bench samples the interrupt one clock before that point and again at that point, for every rate code. Flag snapshots and clears take effect at the edge of the read or write strobe, so status is peeked on the next falling edge.

// File: rtl/spi_byte_master.sv
module spi_byte_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic       irq
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic [7:0] ctrl;
  logic       busy;
  logic [3:0] half;
  logic [3:0] tcnt;
  logic [7:0] sh;
  logic       samp;
  logic       f_done, f_wcol;
  logic       cap_done, cap_wcol;

  logic       en, cpol, cpha;
  logic [3:0] hl_m1;
  logic       tick, wr_data, rd_data, rd_stat, start, coll, finish, data_acc;

  assign en   = ctrl[6];
  assign cpol = ctrl[3];
  assign cpha = ctrl[2];

  always_comb begin
    case (ctrl[1:0])
      2'd0:    hl_m1 = 4'd0;
      2'd1:    hl_m1 = 4'd1;
      2'd2:    hl_m1 = 4'd7;
      default: hl_m1 = 4'd15;
    endcase
  end

  assign tick     = busy && (tcnt == hl_m1);
  assign wr_data  = bus_wr && (bus_addr == A_DATA);
  assign rd_data  = bus_rd && (bus_addr == A_DATA);
  assign rd_stat  = bus_rd && (bus_addr == A_STAT);
  assign start    = wr_data && en && !busy;
  assign coll     = wr_data && en && busy;
  assign finish   = tick && en && (half == 4'd15);
  assign data_acc = rd_data || (wr_data && en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      busy <= 1'b0;
      half <= '0;
      tcnt <= '0;
      sh   <= '0;
      samp <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl <= bus_wdata & 8'hCF;
      if (start) begin
        busy <= 1'b1;
        half <= '0;
        tcnt <= '0;
        sh   <= bus_wdata;
      end else if (busy) begin
        if (!en) begin
          busy <= 1'b0;
        end else if (tick) begin
          tcnt <= '0;
          half <= half + 4'd1;
          if (!half[0]) samp <= miso;
          else          sh   <= {sh[6:0], samp};
          if (half == 4'd15) busy <= 1'b0;
        end else begin
          tcnt <= tcnt + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_done   <= 1'b0;
      f_wcol   <= 1'b0;
      cap_done <= 1'b0;
      cap_wcol <= 1'b0;
    end else begin
      f_done   <= (f_done & ~(data_acc & cap_done)) | finish;
      f_wcol   <= (f_wcol & ~(data_acc & cap_wcol)) | coll;
      cap_done <= (rd_stat ? f_done : (data_acc ? 1'b0 : cap_done)) & ~finish;
      cap_wcol <= (rd_stat ? f_wcol : (data_acc ? 1'b0 : cap_wcol)) & ~coll;
    end
  end

  assign sck  = busy ? (cpol ^ cpha ^ half[0]) : cpol;
  assign mosi = sh[7];
  assign irq  = ctrl[7] & f_done;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = {f_done, f_wcol, 6'b0};
      A_DATA:  bus_rdata = sh;
      default: bus_rdata = 8'h00;
    endcase
  end

  a_r5_done_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_done) |-> ($past(busy) && !busy));

  a_r3_collision_keeps_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && !finish) |=> (busy && f_wcol));

  a_r2_disabled_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !en && !busy) |=> !busy);

  a_r8_status_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && !bus_rd && !finish) |=> ($stable(f_done) && $stable(f_wcol)));

  a_r9_late_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !cap_done && f_done) |=> f_done);

endmodule

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic sck, mosi, miso, irq;

  int n_vec = 0, n_err = 0;
  logic [7:0] s_tx = 8'h00, s_rx = 8'h00;
  int s_n = 0;
  bit s_on = 1'b0;
  logic s_cpol = 1'b0, s_cpha = 1'b0;
  int n_sck = 0;

  always #2 clk = ~clk;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(rd), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .irq(irq));

  assign miso = (s_n < 8) ? s_tx[3'(7 - s_n)] : 1'b0;

  always @(sck) begin
    n_sck++;
    if (s_on && (s_cpha ? (sck == s_cpol) : (sck != s_cpol))) begin
      s_rx = {s_rx[6:0], mosi};
      s_n++;
    end
  end

  // ctrl, master byte, slave byte
  localparam logic [23:0] VEC [8] = '{
    {8'hC0, 8'hA5, 8'h3C}, {8'hC1, 8'h81, 8'h7E},
    {8'hC2, 8'h0F, 8'hF0}, {8'hC3, 8'h5A, 8'hC3},
    {8'hC4, 8'h96, 8'h01}, {8'hC9, 8'h80, 8'hFF},
    {8'hCE, 8'h01, 8'h80}, {8'hCD, 8'hE7, 8'h24}};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 2000 && !irq; k++) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(2'd1, d); chk("R8 reset status, mode fault zero", d, 8'h00);
    chk("R6 reset sck idle", {7'b0, sck}, 8'h00);
    chk("R5 reset irq", {7'b0, irq}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] c, t, s;
      int hl;
      c = VEC[i][23:16]; t = VEC[i][15:8]; s = VEC[i][7:0];
      hl = (c[1:0] == 2'd0) ? 1 : (c[1:0] == 2'd1) ? 2 : (c[1:0] == 2'd2) ? 8 : 16;
      wr_reg(2'd0, c);
      s_cpol = c[3]; s_cpha = c[2];
      s_tx = s; s_rx = 8'h00; s_n = 0; s_on = 1'b1;
      wr_reg(2'd2, t);
      chk("R4 first bit on mosi", {7'b0, mosi}, {7'b0, t[7]});
      chk("R6 first half-period sck level", {7'b0, sck}, {7'b0, c[3] ^ c[2]});
      repeat (16 * hl - 1) @(negedge clk);
      chk("R1 not yet complete", {7'b0, irq}, 8'h00);
      @(negedge clk);
      chk("R1 R5 complete with irq", {7'b0, irq}, 8'h01);
      chk("R6 sck back to idle", {7'b0, sck}, {7'b0, c[3]});
      s_on = 1'b0;
      rd_reg(2'd1, d); chk("R5 status complete", d, 8'h80);
      rd_reg(2'd2, d); chk("R4 received byte", d, s);
      chk("R4 slave saw msb-first byte", s_rx, t);
      peek(2'd1, d); chk("R7 flags cleared by data read", d, 8'h00);
    end

    // R2: disabled write
    wr_reg(2'd0, 8'h80);
    peek(2'd2, prev);
    n_sck = 0;
    wr_reg(2'd2, 8'h5A);
    repeat (40) @(negedge clk);
    chk("R2 no sck activity", 8'(n_sck), 8'h00);
    peek(2'd2, d); chk("R2 data unchanged", d, prev);
    peek(2'd1, d); chk("R2 no flags", d, 8'h00);
    peek(2'd0, d); chk("R2 control readback", d, 8'h80);

    // R3 collision, R9 late flag
    wr_reg(2'd0, 8'hC1);
    s_cpol = 1'b0; s_cpha = 1'b0; s_tx = 8'h3C; s_rx = 8'h00; s_n = 0; s_on = 1'b1;
    wr_reg(2'd2, 8'hA5);
    repeat (4) @(negedge clk);
    wr_reg(2'd2, 8'hFF);
    peek(2'd1, d); chk("R3 collision flag", d, 8'h40);
    rd_reg(2'd1, d);
    wait_irq();
    s_on = 1'b0;
    chk("R3 shifted byte undisturbed", s_rx, 8'hA5);
    peek(2'd1, d); chk("R3 both flags", d, 8'hC0);
    rd_reg(2'd2, d); chk("R3 received byte", d, 8'h3C);
    peek(2'd1, d); chk("R9 late complete flag kept", d, 8'h80);
    chk("R9 irq still high", {7'b0, irq}, 8'h01);

    // R8 status write
    wr_reg(2'd1, 8'h00);
    peek(2'd1, d); chk("R8 status write ignored", d, 8'h80);

    // R7 clear through enabled data write
    rd_reg(2'd1, d);
    wr_reg(2'd2, 8'h11);
    peek(2'd1, d); chk("R7 flags cleared by data write", d, 8'h00);
    wait_irq();
    peek(2'd1, d); chk("R5 complete after write-cleared", d, 8'h80);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule